// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block produces the address for each beat of a four-beat burst. When a burst starts, through either the processor-side start strobe or the controller-side start strobe, it captures the full external address. After that, each advance strobe moves the two lowest address bits to the next beat. The bits above them keep the value captured at the start, so a burst never carries into the upper address.

A static mode pin chooses the beat order. In linear order the two low bits count up modulo four from the start value. In interleaved order the start value is XORed with a beat index of 0 to 3. After the fourth beat the sequence returns to its start value. The surrounding controller combines the remaining chip selects into a single enable, which qualifies both start strobes. Chip select 1 is handled inside the block.

Top module: `burst_addr_seq`

## Requirements
- R1: Reset (active-low `rst_n`, asynchronous) drives `cur_addr` to zero and `last_beat` to 0.
- R2: On a rising edge where `adsp_n`=0, `cs1_n`=0 and `sel_ok`=1, `cur_addr` takes the value of `ext_addr` and the beat index restarts at 0. This applies even in the middle of a burst.
- R3: On a rising edge where `adsc_n`=0 and `sel_ok`=1, a load takes place only if `adsp_n`=1. If `adsp_n`=0 and `cs1_n`=1 on that edge, nothing is loaded.
- R4: On an edge where `adsp_n`=0 and `cs1_n`=1, with `adsc_n`=1, the processor-side strobe is blocked and `cur_addr` does not change.
- R5: With `ilv`=0, each advance sets the low two bits to (start + beat) mod 4. A start of 01 gives 01, 10, 11, 00.
- R6: With `ilv`=1, each advance sets the low two bits to start XOR beat. A start of 01 gives 01, 00, 11, 10. A start of 10 gives 10, 11, 00, 01.
- R7: On the edge that performs a load, `adv_n` has no effect. The first beat always shows the loaded address.
- R8: On an edge with no load and `adv_n`=1, `cur_addr` and `last_beat` keep their values (burst suspend).
- R9: An advance from the fourth beat returns `cur_addr` to the start address.
- R10: Outside a load, bits AW-1..2 of `cur_addr` never change, including when the low bits roll over from 11 to 00.
- R11: `last_beat` is 1 exactly while the fourth beat (beat index 3) is presented, and it stays 1 during a suspend on that beat.
- R12: When `sel_ok`=0, neither start strobe loads anything and `cur_addr` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| adsp_n | input | 1 | Processor-side burst start, active low |
| adsc_n | input | 1 | Controller-side burst start, active low |
| adv_n | input | 1 | Advance to next beat, active low |
| cs1_n | input | 1 | Chip select 1, active low; gates the processor-side start |
| sel_ok | input | 1 | Qualification from the controller's other chip selects, active high |
| ilv | input | 1 | Beat order: 0 linear, 1 interleaved |
| ext_addr | input | AW | External start address |
| cur_addr | output | AW | Address of the current beat |
| last_beat | output | 1 | High while the fourth beat is presented |

## Verification
The sequencer keeps a registered base address and a two-bit beat index. Any corruption of either one shows up on `cur_addr` after the first rising edge that follows it. A wrong start capture is visible on the first beat. A wrong step, order or wrap appears on the very next advance. A stray upper-bit change or a load that should have been blocked appears in the cycle right after the offending edge. An index that is off by one also makes `last_beat` appear on the wrong beat. No error can stay hidden for more than the four edges of one burst.

// File: rtl/burst_addr_seq.sv
module burst_addr_seq #(
  parameter int AW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adsp_n,
  input  logic          adsc_n,
  input  logic          adv_n,
  input  logic          cs1_n,
  input  logic          sel_ok,
  input  logic          ilv,
  input  logic [AW-1:0] ext_addr,
  output logic [AW-1:0] cur_addr,
  output logic          last_beat
);

  localparam int LW = 2;
  localparam logic [LW-1:0] LAST = '1;

  logic [AW-1:0] base_q;
  logic [LW-1:0] beat_q;
  logic [LW-1:0] low;
  logic          load;

  assign load = sel_ok & ((~adsp_n & ~cs1_n) | (~adsc_n & adsp_n));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      beat_q <= '0;
    end else if (load) begin
      base_q <= ext_addr;
      beat_q <= '0;
    end else if (!adv_n) begin
      beat_q <= beat_q + 1'b1;
    end
  end

  assign low       = ilv ? (base_q[LW-1:0] ^ beat_q) : (base_q[LW-1:0] + beat_q);
  assign cur_addr  = {base_q[AW-1:LW], low};
  assign last_beat = (beat_q == LAST);

endmodule

module burst_addr_seq_chk #(
  parameter int AW = 20
) (
  input logic          clk,
  input logic          rst_n,
  input logic          adsp_n,
  input logic          adsc_n,
  input logic          adv_n,
  input logic          cs1_n,
  input logic          sel_ok,
  input logic          ilv,
  input logic [AW-1:0] ext_addr,
  input logic [AW-1:0] cur_addr,
  input logic          last_beat
);

  logic go;
  assign go = sel_ok & ((~adsp_n & ~cs1_n) | (~adsc_n & adsp_n));

  assert_proc_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_ok && !adsp_n && !cs1_n) |=> (cur_addr == $past(ext_addr) && !last_beat));

  assert_blocked_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!adsp_n && cs1_n && adsc_n && adv_n) |=> $stable(cur_addr));

  assert_no_select_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_ok && adv_n) |=> $stable(cur_addr));

  assert_suspend_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!go && adv_n) |=> ($stable(cur_addr) && $stable(last_beat)));

  assert_upper_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !go |=> (cur_addr[AW-1:2] == $past(cur_addr[AW-1:2])));

  assert_linear_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!go && !adv_n && !ilv) |=> (cur_addr[1:0] == $past(cur_addr[1:0]) + 2'd1));

  assert_last_leaves_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (last_beat && !go && !adv_n) |=> !last_beat);

endmodule

bind burst_addr_seq burst_addr_seq_chk #(.AW(AW)) chk (
  .clk(clk), .rst_n(rst_n), .adsp_n(adsp_n), .adsc_n(adsc_n), .adv_n(adv_n),
  .cs1_n(cs1_n), .sel_ok(sel_ok), .ilv(ilv), .ext_addr(ext_addr),
  .cur_addr(cur_addr), .last_beat(last_beat)
);

// File: tb/burst_addr_seq_test.sv
module burst_addr_seq_test;
  localparam int AW = 20;
  localparam int NV = 20;
  localparam int VW = 6 + AW + AW + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic adsp_n = 1'b1, adsc_n = 1'b1, adv_n = 1'b1, cs1_n = 1'b1, sel_ok = 1'b1, ilv = 1'b0;
  logic [AW-1:0] ext_addr = '0;
  logic [AW-1:0] cur_addr;
  logic last_beat;
  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  always #2 clk = ~clk;

  burst_addr_seq #(.AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .adsp_n(adsp_n), .adsc_n(adsc_n), .adv_n(adv_n),
    .cs1_n(cs1_n), .sel_ok(sel_ok), .ilv(ilv), .ext_addr(ext_addr),
    .cur_addr(cur_addr), .last_beat(last_beat)
  );

  // {adsp_n, adsc_n, adv_n, cs1_n, sel_ok, ilv}, ext_addr, expected cur_addr, expected last_beat
  localparam logic [VW-1:0] VEC [NV] = '{
    {6'b010010, 20'hABCD1, 20'hABCD1, 1'b0},  // R2 R7 load, adv ignored
    {6'b110010, 20'h00000, 20'hABCD2, 1'b0},  // R5
    {6'b111010, 20'h00000, 20'hABCD2, 1'b0},  // R8 suspend
    {6'b110010, 20'h00000, 20'hABCD3, 1'b0},  // R5
    {6'b110010, 20'h00000, 20'hABCD0, 1'b1},  // R10 R11 no carry, fourth beat
    {6'b110010, 20'h00000, 20'hABCD1, 1'b0},  // R9 wrap
    {6'b011110, 20'h12345, 20'hABCD1, 1'b0},  // R4 blocked by cs1
    {6'b001110, 20'h12345, 20'hABCD1, 1'b0},  // R3 controller strobe with adsp low
    {6'b100111, 20'h55556, 20'h55556, 1'b0},  // R3 R7 controller load
    {6'b110011, 20'h00000, 20'h55557, 1'b0},  // R6
    {6'b110011, 20'h00000, 20'h55554, 1'b0},  // R6
    {6'b110011, 20'h00000, 20'h55555, 1'b1},  // R6 R11
    {6'b110011, 20'h00000, 20'h55556, 1'b0},  // R9
    {6'b011001, 20'h12345, 20'h55556, 1'b0},  // R12 processor strobe
    {6'b101001, 20'h00000, 20'h55556, 1'b0},  // R12 controller strobe
    {6'b011011, 20'h0000D, 20'h0000D, 1'b0},  // R2
    {6'b110011, 20'h00000, 20'h0000C, 1'b0},  // R6
    {6'b110011, 20'h00000, 20'h0000F, 1'b0},  // R6
    {6'b110011, 20'h00000, 20'h0000E, 1'b1},  // R11
    {6'b111011, 20'h00000, 20'h0000E, 1'b1}   // R11 R8 suspend on last beat
  };

  task automatic check(input string req, input logic [AW-1:0] ea, input logic el);
    checks++;
    if (cur_addr !== ea || last_beat !== el) begin
      errors++;
      $display("FAIL %s: addr=%h last=%b expected addr=%h last=%b", req, cur_addr, last_beat, ea, el);
    end
  endtask

  task automatic step(input logic [5:0] c, input logic [AW-1:0] ea);
    @(negedge clk);
    {adsp_n, adsc_n, adv_n, cs1_n, sel_ok, ilv} = c;
    ext_addr = ea;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #3;
    check("R1", '0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][VW-1 -: 6], VEC[i][VW-7 -: AW]);
      check($sformatf("R-vector %0d", i), VEC[i][AW:1], VEC[i][0]);
    end
    // R2 R7: reload in mid burst from the fourth beat, advance requested
    step(6'b010011, 20'hFFFFF);
    check("R2", 20'hFFFFF, 1'b0);
    // R6: start 11 interleaved, second beat 10
    step(6'b110011, 20'h00000);
    check("R6", 20'hFFFFE, 1'b0);
    // R1: reset in mid burst
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1", '0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (2000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not complete");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule